// File: doc/BRIEF.md
# Banded Matrix-Vector Systolic Array

This block multiplies a banded matrix by a vector, y = A·x. The matrix has P−1 nonzero diagonals above the main diagonal and Q−1 below it, so each row holds at most P+Q−1 entries. The block is a linear chain of P+Q−1 multiply-accumulate cells. Vector elements enter at one end and travel towards the far end, one cell per clock. Partial sums start at zero at the far end and travel back towards the first cell. The two streams cross at every cell.

Each cell has its own side input for band entries. The caller delivers every matrix entry to the cell where its row's partial sum meets its column's vector element, on the cycle when they meet. The cell multiplies the entry by the passing vector element and adds the product to the passing partial sum. A finished y[i] leaves the first cell, marked by a valid strobe. Vector elements are applied only on every other cycle, and the idle slot between them keeps the two opposing streams aligned. Several vectors may follow one another without a pause, as long as band slots that fall outside a matrix are marked invalid.

Top module: `sa_band_mvm`

## Requirements
- R1: The chain has CELLS = P+Q−1 cells. For a vector of n elements, the result is y_i = Σ a_ij·x_j over 1 ≤ j ≤ n with −(Q−1) ≤ j−i ≤ P−1. Positions outside 1..n contribute nothing. This includes n = 1.
- R2: Within one vector, x_j is applied with `x_vld` high on edge s+2(j−1), where s is the edge that takes x_1. `x_vld` is never high on two edges in a row, and `y_vld` is never high on two edges in a row.
- R3: Entry a_ij goes to cell k = (P−1)−(j−i). It is presented on `a_vld[k]` and `a_dat[k*DATA_W +: DATA_W]` at edge s+2(j−1)+k+1+max(Q−P,0).
- R4: Result y_i appears on `y_sum` with `y_vld` high right after edge s+2(i−1)+CELLS+max(P−Q,0). There is exactly one result per vector element, and results come out in order.
- R5: On every cycle where `y_vld` is low, `y_sum` keeps the value it had on the previous cycle.
- R6: A band entry presented with its valid bit low contributes zero, whatever its data.
- R7: A band entry presented with its valid bit high on a cell and cycle where no vector element meets a partial sum has no effect on any result.
- R8: Synchronous reset drives `y_vld` and `y_sum` to zero and discards all work in flight. Inputs applied during reset produce no result.
- R9: Operands are signed two's-complement DATA_W-bit numbers. Sums are signed SUM_W-bit numbers. With the defaults, full-scale operands such as (−128)·(−128) summed over three terms come out exact.
- R10: Vectors may follow one another back to back, or after any gap. A vector's results do not mix with data from a neighbouring vector, provided band slots outside each matrix are driven invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_vld | input | 1 | Vector element strobe; must not be high on two edges in a row |
| x_dat | input | DATA_W | Vector element, signed |
| a_vld | input | CELLS | Per-cell band entry strobe |
| a_dat | input | CELLS*DATA_W | Per-cell band entry; cell k uses bits [k*DATA_W +: DATA_W] |
| y_vld | output | 1 | High for one cycle when a finished y_i is on `y_sum` |
| y_sum | output | SUM_W | Result y_i, signed; held between results |

## Verification
The bench builds each band-entry schedule from the meeting rule and checks every result for both its value and the cycle it appears in.

- **Off-by-one schedule:** a design that delivers entries one cell or one cycle off computes sums with the wrong terms, or raises the strobe at the wrong time.
- **Edge-of-matrix rows and single-element vectors:** these catch a chain that fails to treat missing neighbours as zero.
- **Full-scale negative operands:** these expose a multiply that is not signed, or a sum that does not sign-extend.
- **Invalid entries carrying garbage data:** a cell that ignores the per-entry valid bit adds the garbage.
- **Valid entries at slots where nothing meets:** a cell that accumulates without checking both stream valids adds these stray values.
- **Back-to-back vectors and mid-stream reset:** these catch partial sums leaking between vectors, and leftover results surviving a reset.

// File: rtl/sa_band_pkg.sv
`timescale 1ns/1ps
package sa_band_pkg;

    // What a cell does with the partial sum passing through it this cycle
    typedef enum logic [1:0] {
        CELL_IDLE = 2'd0,   // no partial sum present
        CELL_PASS = 2'd1,   // partial sum present, nothing to accumulate
        CELL_MAC  = 2'd2    // partial sum, vector element and band entry all present
    } cell_op_e;

    // Number of cells = number of diagonals in the band
    function automatic int band_cells(input int p, input int q);
        return p + q - 1;
    endfunction

    // Extra stages on the vector path when the lower band is wider
    function automatic int x_lead(input int p, input int q);
        return (q > p) ? (q - p) : 0;
    endfunction

    // Extra stages on the zero-injection trigger when the upper band is wider
    function automatic int y_lag(input int p, input int q);
        return (p > q) ? (p - q) : 0;
    endfunction

endpackage

// File: rtl/sa_band_delay.sv
`timescale 1ns/1ps
module sa_band_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] d_o
);

    typedef logic [WIDTH-1:0] word_t;

    word_t stage_d [DEPTH];
    word_t stage_q [DEPTH];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < DEPTH; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign d_o = stage_q[DEPTH-1];

endmodule

// File: rtl/sa_band_cell.sv
`timescale 1ns/1ps
module sa_band_cell
    import sa_band_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    // vector stream, travelling away from the first cell
    input  logic                     x_vld_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     x_vld_o,
    output logic signed [DATA_W-1:0] x_o,
    // partial-sum stream, travelling towards the first cell
    input  logic                     y_vld_i,
    input  logic signed [SUM_W-1:0]  y_i,
    output logic                     y_vld_o,
    output logic signed [SUM_W-1:0]  y_o,
    // band entry from the side
    input  logic                     a_vld_i,
    input  logic signed [DATA_W-1:0] a_i
);

    localparam int PROD_W = 2 * DATA_W;

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic                     x_vld;
        logic signed [DATA_W-1:0] x;
        logic                     y_vld;
        logic signed [SUM_W-1:0]  y;
    } cell_t;

    cell_t    cur_d, cur_q;
    cell_op_e op;
    prod_t    prod;
    sum_t     prod_ext;

    assign prod     = prod_t'(a_i) * prod_t'(x_i);
    assign prod_ext = sum_t'(prod);

    always_comb begin
        op = CELL_IDLE;
        if (y_vld_i) begin
            op = (x_vld_i && a_vld_i) ? CELL_MAC : CELL_PASS;
        end

        cur_d       = cur_q;
        cur_d.x_vld = x_vld_i;
        if (x_vld_i) begin
            cur_d.x = x_i;
        end
        cur_d.y_vld = y_vld_i;
        unique case (op)
            CELL_MAC:  cur_d.y = y_i + prod_ext;
            CELL_PASS: cur_d.y = y_i;
            default:   cur_d.y = cur_q.y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign x_vld_o = cur_q.x_vld;
    assign x_o     = cur_q.x;
    assign y_vld_o = cur_q.y_vld;
    assign y_o     = cur_q.y;

endmodule

// File: rtl/sa_band_mvm.sv
`timescale 1ns/1ps
module sa_band_mvm
    import sa_band_pkg::*;
#(
    parameter int  P      = 2,
    parameter int  Q      = 2,
    parameter int  DATA_W = 8,
    parameter int  SUM_W  = 20,
    localparam int CELLS  = band_cells(P, Q)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    x_vld,
    input  logic [DATA_W-1:0]       x_dat,
    input  logic [CELLS-1:0]        a_vld,
    input  logic [CELLS*DATA_W-1:0] a_dat,
    output logic                    y_vld,
    output logic [SUM_W-1:0]        y_sum
);

    localparam int X_DEPTH = 1 + x_lead(P, Q);
    localparam int Y_DEPTH = 1 + y_lag(P, Q);

    // chain nets: x_* index k feeds cell k; y_* index k+1 feeds cell k
    logic                     x_vld_ch [CELLS+1];
    logic signed [DATA_W-1:0] x_ch     [CELLS+1];
    logic                     y_vld_ch [CELLS+1];
    logic signed [SUM_W-1:0]  y_ch     [CELLS+1];

    logic [DATA_W:0] x_aligned;
    logic            inject;

    // vector element alignment stage(s)
    sa_band_delay #(
        .WIDTH (DATA_W + 1),
        .DEPTH (X_DEPTH)
    ) u_x_align (
        .clk (clk),
        .rst (rst),
        .d_i ({x_vld, x_dat}),
        .d_o (x_aligned)
    );

    // zero partial-sum injection trigger, paired with each vector element
    sa_band_delay #(
        .WIDTH (1),
        .DEPTH (Y_DEPTH)
    ) u_y_inject (
        .clk (clk),
        .rst (rst),
        .d_i (x_vld),
        .d_o (inject)
    );

    assign x_vld_ch[0]  = x_aligned[DATA_W];
    assign x_ch[0]      = x_aligned[DATA_W-1:0];
    assign y_vld_ch[CELLS] = inject;
    assign y_ch[CELLS]     = '0;

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        sa_band_cell #(
            .DATA_W (DATA_W),
            .SUM_W  (SUM_W)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .x_vld_i (x_vld_ch[k]),
            .x_i     (x_ch[k]),
            .x_vld_o (x_vld_ch[k+1]),
            .x_o     (x_ch[k+1]),
            .y_vld_i (y_vld_ch[k+1]),
            .y_i     (y_ch[k+1]),
            .y_vld_o (y_vld_ch[k]),
            .y_o     (y_ch[k]),
            .a_vld_i (a_vld[k]),
            .a_i     (a_dat[k*DATA_W +: DATA_W])
        );
    end

    assign y_vld = y_vld_ch[0];
    assign y_sum = y_ch[0];

endmodule

// File: rtl/sa_band_mvm_chk.sv
`timescale 1ns/1ps
module sa_band_mvm_chk #(
    parameter int SUM_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             x_vld,
    input logic             y_vld,
    input logic [SUM_W-1:0] y_sum
);

    int unsigned n_in_q;
    int unsigned n_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_in_q  <= 0;
            n_out_q <= 0;
        end else begin
            if (x_vld) n_in_q  <= n_in_q + 1;
            if (y_vld) n_out_q <= n_out_q + 1;
        end
    end

    // R2: input protocol, elements only every other edge
    p_x_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        x_vld |=> !x_vld);

    // R2: results leave in alternate slots
    p_y_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        y_vld |=> !y_vld);

    // R5: output word held while no result is flagged
    p_y_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !y_vld |-> $stable(y_sum));

    // R4: never more results than vector elements taken
    p_no_extra_result_r4: assert property (@(posedge clk) disable iff (rst)
        n_out_q <= n_in_q);

    // R8: nothing flagged on the first edge after reset
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !y_vld);

endmodule

bind sa_band_mvm sa_band_mvm_chk #(
    .SUM_W (SUM_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .x_vld (x_vld),
    .y_vld (y_vld),
    .y_sum (y_sum)
);

// File: tb/sim_sa_band_mvm.sv
`timescale 1ns/1ps
module sim_sa_band_mvm;

    localparam int P  = 2;
    localparam int Q  = 2;
    localparam int DW = 8;
    localparam int SW = 20;
    localparam int W  = P + Q - 1;
    localparam int DX = (Q > P) ? Q - P : 0;
    localparam int DY = (P > Q) ? P - Q : 0;
    localparam int NC = 160;
    localparam int NM = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              x_vld = 1'b0;
    logic [DW-1:0]     x_dat = '0;
    logic [W-1:0]      a_vld = '0;
    logic [W*DW-1:0]   a_dat = '0;
    logic              y_vld;
    logic [SW-1:0]     y_sum;

    always #5 clk = ~clk;

    sa_band_mvm #(.P(P), .Q(Q), .DATA_W(DW), .SUM_W(SW)) u0 (
        .clk(clk), .rst(rst), .x_vld(x_vld), .x_dat(x_dat),
        .a_vld(a_vld), .a_dat(a_dat), .y_vld(y_vld), .y_sum(y_sum)
    );

    int n_chk = 0;
    int n_bad = 0;

    int mat [NM][NM];
    bit mv  [NM][NM];
    int xv  [NM];

    bit sx_v [NC];
    int sx_d [NC];
    bit sa_v [NC][W];
    int sa_d [NC][W];
    bit ex_v [NC];
    int ex_d [NC];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int ysig();
        return int'($signed(y_sum));
    endfunction

    function automatic int rnd8();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    task automatic clear_sched();
        for (int c = 0; c < NC; c++) begin
            sx_v[c] = 0; sx_d[c] = 0; ex_v[c] = 0; ex_d[c] = 0;
            for (int k = 0; k < W; k++) begin
                sa_v[c][k] = 0; sa_d[c][k] = 0;
            end
        end
    endtask

    // random matrix and vector; drop_pct of band entries become invalid
    task automatic fill_rand(input int n, input int drop_pct);
        for (int i = 1; i <= n; i++) begin
            xv[i] = rnd8();
            for (int j = 1; j <= n; j++) begin
                mat[i][j] = rnd8();
                mv[i][j]  = (int'($urandom_range(0, 99)) >= drop_pct);
            end
        end
    endtask

    // schedule one vector starting at edge s (R2, R3) and its results (R1, R4)
    task automatic add_vec(input int s, input int n);
        for (int j = 1; j <= n; j++) begin
            sx_v[s + 2*(j-1)] = 1;
            sx_d[s + 2*(j-1)] = xv[j];
        end
        for (int i = 1; i <= n; i++) begin
            int acc = 0;
            for (int j = 1; j <= n; j++) begin
                if ((j - i) <= P - 1 && (i - j) <= Q - 1) begin
                    int k = (P - 1) - (j - i);
                    int c = s + 2*(j-1) + k + 1 + DX;
                    sa_v[c][k] = mv[i][j];
                    sa_d[c][k] = mat[i][j];
                    if (mv[i][j]) acc += mat[i][j] * xv[j];
                end
            end
            ex_v[s + 2*(i-1) + W + DY] = 1;
            ex_d[s + 2*(i-1) + W + DY] = acc;
        end
    endtask

    task automatic drive(input int c);
        x_vld = sx_v[c];
        x_dat = sx_d[c][DW-1:0];
        for (int k = 0; k < W; k++) begin
            a_vld[k] = sa_v[c][k];
            a_dat[k*DW +: DW] = sa_d[c][k][DW-1:0];
        end
    endtask

    task automatic idle_inputs();
        x_vld = 0; x_dat = '0; a_vld = '0; a_dat = '0;
    endtask

    task automatic run(input int ncyc, input string rq);
        int prev_y = ysig();
        bit prev_v = 0;
        for (int c = 0; c < ncyc; c++) begin
            drive(c);
            @(posedge clk);
            #1;
            chk(y_vld === ex_v[c], "R4", $sformatf("%s strobe at cycle %0d", rq, c),
                int'(y_vld), int'(ex_v[c]));
            if (ex_v[c] && y_vld)
                chk(ysig() == ex_d[c], rq, $sformatf("result at cycle %0d", c),
                    ysig(), ex_d[c]);
            if (!y_vld)
                chk(ysig() == prev_y, "R5", $sformatf("hold at cycle %0d", c),
                    ysig(), prev_y);
            if (prev_v)
                chk(!y_vld, "R2", $sformatf("spacing at cycle %0d", c), int'(y_vld), 0);
            prev_v = y_vld;
            prev_y = ysig();
        end
        idle_inputs();
    endtask

    // R8: reset state, inputs during reset, reset mid-stream
    task automatic t_reset();
        rst = 1;
        x_vld = 1; x_dat = 8'h55; a_vld = '1; a_dat = '1;
        repeat (4) @(posedge clk);
        #1;
        idle_inputs();
        rst = 0;
        chk(y_vld === 1'b0, "R8", "strobe in reset", int'(y_vld), 0);
        chk(ysig() == 0, "R8", "sum in reset", ysig(), 0);
        clear_sched();
        run(12, "R8");
        clear_sched();
        fill_rand(4, 0);
        add_vec(0, 4);
        run(3, "R8");
        rst = 1;
        repeat (2) @(posedge clk);
        #1;
        rst = 0;
        chk(ysig() == 0, "R8", "sum cleared mid-stream", ysig(), 0);
        clear_sched();
        run(16, "R8");
    endtask

    // R1: diagonal only, result equals vector
    task automatic t_diag();
        clear_sched();
        fill_rand(4, 0);
        for (int i = 1; i <= 4; i++)
            for (int j = 1; j <= 4; j++)
                mv[i][j] = (i == j);
        add_vec(0, 4);
        run(16, "R1");
    endtask

    // R1, R3: full band, random
    task automatic t_full();
        clear_sched();
        fill_rand(6, 0);
        add_vec(0, 6);
        run(22, "R3");
        clear_sched();
        fill_rand(5, 0);
        add_vec(1, 5);
        run(20, "R1");
    endtask

    // R1: single-element vector
    task automatic t_single();
        clear_sched();
        fill_rand(1, 0);
        add_vec(0, 1);
        run(8, "R1");
    endtask

    // R9: full-scale signed operands
    task automatic t_signed();
        clear_sched();
        for (int i = 1; i <= 3; i++) begin
            xv[i] = -128;
            for (int j = 1; j <= 3; j++) begin
                mat[i][j] = -128; mv[i][j] = 1;
            end
        end
        add_vec(0, 3);
        run(12, "R9");
        clear_sched();
        for (int i = 1; i <= 3; i++) begin
            xv[i] = 127;
            for (int j = 1; j <= 3; j++) mat[i][j] = -128;
        end
        add_vec(0, 3);
        run(12, "R9");
    endtask

    // R6: invalid band entries carry garbage data
    task automatic t_invalid();
        clear_sched();
        fill_rand(6, 50);
        add_vec(0, 6);
        run(22, "R6");
    endtask

    // R7: valid entries at slots where nothing meets
    task automatic t_stray();
        clear_sched();
        fill_rand(5, 0);
        add_vec(0, 5);
        for (int c = 0; c < 24; c++)
            for (int k = 0; k < W; k++)
                if (!sa_v[c][k]) begin
                    sa_v[c][k] = 1;
                    sa_d[c][k] = rnd8();
                end
        run(24, "R7");
    endtask

    // R10: back-to-back vectors, then an odd gap
    task automatic t_stream();
        clear_sched();
        fill_rand(4, 0);
        add_vec(0, 4);
        fill_rand(3, 0);
        add_vec(8, 3);
        fill_rand(2, 0);
        add_vec(17, 2);
        run(30, "R10");
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_diag();
        t_full();
        t_single();
        t_signed();
        t_invalid();
        t_stray();
        t_stream();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule